// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

This block steps through a small route table in lockstep with a serial TDM frame, one bit per clock. For every bit it reports which channel owns the current slot. It also chooses the physical line that carries the data. The receive side and the transmit side each have their own table and their own frame sync. Both run on a shared bit clock.

Each table entry describes one group of consecutive bits. An entry holds a length, a resolution flag that selects bits or bytes, a channel number, a swap flag and an end-of-frame flag. A set swap flag reverses the roles of the two serial lines for that group:

- Receive data is taken from the line normally used for transmit.
- Transmit data is driven onto the line normally used for receive.

Outside swapped transmit slots, the receive-side line is never driven. This leaves quiet slots free for other stations.

Each direction has a primary and a shadow table. A single request input chooses between them. The change takes effect only when a clean frame boundary is crossed. Two pulse outputs flag configuration and timing faults: a frame that closes on a one-bit group, and a sync that arrives mid-frame.

Top module: `tdm_route_seq`

## Requirements
- R1: After reset, both directions are idle and both channel outputs are 0. Every line enable is low, rx_bit_vld is low and the primary table is active (rx_tbl_act = tx_tbl_act = 0). Each direction stays idle until its own sync arrives.
- R2: A sync sampled high at a clock edge starts that direction at entry 0. Bit 0 of that entry is presented in the cycle that follows the edge.
- R3: An entry occupies cnt+1 bit cycles when byt = 0, and (cnt+1)*8 bit cycles when byt = 1. The entry is 8 bits wide: cnt in bits [2:0], byt in bit 3, channel in bits [5:4], swap in bit 6, last in bit 7. Entry i sits at bits [8i+7:8i] of a table vector.
- R4: A frame ends after the last bit of an odd-indexed entry whose last bit is set, or after entry 15. After the frame ends, the direction goes idle (channel 0, nothing enabled) until the next sync.
- R5: A last flag on an even-indexed entry is ignored, and the walk continues with the next entry.
- R6: A slot whose channel field is 0 shows channel 0. In such a slot rx_bit_vld stays low and neither line is driven.
- R7: In a selected receive slot with swap = 1, rx_bit follows line_txd_i. In a selected receive slot without swap, rx_bit follows line_rxd_i.
- R8: A selected transmit slot with swap = 1 drives tx_bit on line_rxd_o with line_rxd_oe high. A selected transmit slot without swap drives it on line_txd_o with line_txd_oe high. The two enables are never high together.
- R9: The active table of a direction changes to the value of tbl_sel_req only when a sync starts a frame while that direction is idle, or when the sync coincides with the frame's final bit.
- R10: A sync that arrives while a frame is running, other than on its final bit, restarts the walk at entry 0. It also raises that direction's sync-error output for exactly one cycle and leaves the active table unchanged.
- R11: When a frame ends on an entry with cnt = 0 and byt = 0, that direction's cfg-error output pulses high for the single cycle after the final bit.
- R12: The receive and transmit walks proceed independently, each driven only by its own sync and table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_sel_req | input | 1 | Requested table: 0 primary, 1 shadow |
| rx_sync | input | 1 | Receive frame sync |
| tx_sync | input | 1 | Transmit frame sync |
| rx_tbl_pri | input | 128 | Receive primary table, 16 entries of 8 bits |
| rx_tbl_sha | input | 128 | Receive shadow table |
| tx_tbl_pri | input | 128 | Transmit primary table |
| tx_tbl_sha | input | 128 | Transmit shadow table |
| line_rxd_i | input | 1 | Sensed value of the receive-side line |
| line_txd_i | input | 1 | Sensed value of the transmit-side line |
| tx_bit | input | 1 | Transmit data bit for the current slot |
| rx_chan | output | 2 | Receive channel owning this bit, 0 for none |
| rx_bit | output | 1 | Receive data from the routed line |
| rx_bit_vld | output | 1 | Receive slot is selected |
| tx_chan | output | 2 | Transmit channel owning this bit, 0 for none |
| line_rxd_o | output | 1 | Data driven onto the receive-side line |
| line_rxd_oe | output | 1 | Enable for the receive-side line |
| line_txd_o | output | 1 | Data driven onto the transmit-side line |
| line_txd_oe | output | 1 | Enable for the transmit-side line |
| rx_tbl_act | output | 1 | Receive table in use |
| tx_tbl_act | output | 1 | Transmit table in use |
| rx_sync_err | output | 1 | Receive mid-frame sync pulse |
| tx_sync_err | output | 1 | Transmit mid-frame sync pulse |
| rx_cfg_err | output | 1 | Receive frame ended on a one-bit group |
| tx_cfg_err | output | 1 | Transmit frame ended on a one-bit group |

## Verification
The hardest situation to reach is a sync that lands exactly on a frame's final bit while a table change is pending. In that case the sync must switch tables cleanly and raise no error, whereas a sync one bit earlier must raise an error and keep the old table. The stimulus reaches it in two ways. A short transmit frame is paired with syncs on fixed periods of 3 and 2 bits, which hits both the coinciding edge and the early edge repeatedly. After that, a long run of random syncs and random table requests, against a cycle-accurate model in the bench, covers the remaining alignments.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;

   typedef enum logic {
      WS_WAIT = 1'b0,
      WS_RUN  = 1'b1
   } walk_state_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tdm_route_entry_pick.sv
module tdm_route_entry_pick #(
   parameter int N_ENT = 16,
   parameter int EW    = 8,
   parameter int IDX_W = $clog2(N_ENT)
) (
   input  logic [N_ENT*EW-1:0] pri,
   input  logic [N_ENT*EW-1:0] sha,
   input  logic                sel,
   input  logic [IDX_W-1:0]    idx,
   output logic [EW-1:0]       ent
);

   logic [EW-1:0] ent_p [N_ENT];
   logic [EW-1:0] ent_s [N_ENT];

   for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
      assign ent_p[g] = pri[g*EW +: EW];
      assign ent_s[g] = sha[g*EW +: EW];
   end

   assign ent = sel ? ent_s[idx] : ent_p[idx];

endmodule

// File: rtl/tdm_route_walker.sv
module tdm_route_walker
   import tdm_route_pkg::*;
#(
   parameter int N_ENT     = 16,
   parameter int CSEL_W    = 2,
   parameter int CNT_W     = 3,
   parameter int BYTE_BITS = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 sync,
   input  logic                                 sel_req,
   input  logic [N_ENT*(CNT_W+CSEL_W+3)-1:0]    tbl_pri,
   input  logic [N_ENT*(CNT_W+CSEL_W+3)-1:0]    tbl_sha,
   output logic                                 slot_on,
   output logic [CSEL_W-1:0]                    chan,
   output logic                                 swap,
   output logic                                 sel_act,
   output logic                                 sync_err,
   output logic                                 cfg_err
);

   localparam int EW      = CNT_W + CSEL_W + 3;
   localparam int IDX_W   = $clog2(N_ENT);
   localparam int LEN_W   = $clog2((2**CNT_W) * BYTE_BITS);
   localparam int POS_BYT = CNT_W;
   localparam int POS_CS  = CNT_W + 1;
   localparam int POS_SW  = CNT_W + 1 + CSEL_W;
   localparam int POS_LS  = CNT_W + 2 + CSEL_W;

   if (N_ENT % 2 != 0 || N_ENT < 2) begin : g_chk_ent
      $error("N_ENT must be even and at least 2");
   end
   if (LEN_W < CNT_W) begin : g_chk_len
      $error("BYTE_BITS too small for CNT_W");
   end

   walk_state_t         state_q;
   logic [IDX_W-1:0]    idx_q;
   logic [LEN_W-1:0]    bcnt_q;
   logic                sel_q, serr_q, cerr_q;

   logic [EW-1:0]       ent;
   logic [CNT_W-1:0]    ent_cnt;
   logic                ent_byt, ent_swap, ent_last;
   logic [CSEL_W-1:0]   ent_csel;
   logic [LEN_W-1:0]    len_m1;
   logic                running, last_bit, frame_end, single_bit;

   tdm_route_entry_pick #(.N_ENT(N_ENT), .EW(EW), .IDX_W(IDX_W)) u_pick (
      .pri (tbl_pri),
      .sha (tbl_sha),
      .sel (sel_q),
      .idx (idx_q),
      .ent (ent)
   );

   assign ent_cnt  = ent[CNT_W-1:0];
   assign ent_byt  = ent[POS_BYT];
   assign ent_csel = ent[POS_CS +: CSEL_W];
   assign ent_swap = ent[POS_SW];
   assign ent_last = ent[POS_LS];

   if (is_pow2(BYTE_BITS)) begin : g_len_shift
      localparam int SH = $clog2(BYTE_BITS);
      always_comb begin
         if (ent_byt) len_m1 = ((LEN_W'(ent_cnt) + LEN_W'(1)) << SH) - LEN_W'(1);
         else         len_m1 = LEN_W'(ent_cnt);
      end
   end else begin : g_len_mul
      always_comb begin
         if (ent_byt) len_m1 = (LEN_W'(ent_cnt) + LEN_W'(1)) * LEN_W'(BYTE_BITS) - LEN_W'(1);
         else         len_m1 = LEN_W'(ent_cnt);
      end
   end

   assign running    = (state_q == WS_RUN);
   assign last_bit   = running && (bcnt_q == len_m1);
   assign frame_end  = last_bit && ((idx_q[0] && ent_last) || (idx_q == IDX_W'(N_ENT - 1)));
   assign single_bit = (ent_cnt == '0) && !ent_byt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_WAIT;
         idx_q   <= '0;
         bcnt_q  <= '0;
         sel_q   <= 1'b0;
         serr_q  <= 1'b0;
         cerr_q  <= 1'b0;
      end else begin
         serr_q <= 1'b0;
         cerr_q <= frame_end && single_bit;
         if (sync) begin
            state_q <= WS_RUN;
            idx_q   <= '0;
            bcnt_q  <= '0;
            if (running && !frame_end) serr_q <= 1'b1;
            else                       sel_q  <= sel_req;
         end else if (last_bit) begin
            bcnt_q <= '0;
            if (frame_end) begin
               state_q <= WS_WAIT;
               idx_q   <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end else if (running) begin
            bcnt_q <= bcnt_q + LEN_W'(1);
         end
      end
   end

   assign slot_on  = running && (ent_csel != '0);
   assign chan     = running ? ent_csel : '0;
   assign swap     = slot_on && ent_swap;
   assign sel_act  = sel_q;
   assign sync_err = serr_q;
   assign cfg_err  = cerr_q;

   AST_SYNC_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (running && idx_q == '0 && bcnt_q == '0)); // R2
   AST_FRAME_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !sync) |=> !running); // R4
   AST_EVEN_LAST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && !idx_q[0] && !sync) |=> running); // R5
   AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> $stable(sel_q)); // R9
   AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> $past(sync && running)); // R10
   AST_CERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(frame_end)); // R11

endmodule

// File: rtl/tdm_pin_steer.sv
module tdm_pin_steer (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_slot_on,
   input  logic rx_swap,
   input  logic tx_slot_on,
   input  logic tx_swap,
   input  logic line_rxd_i,
   input  logic line_txd_i,
   input  logic tx_bit,
   output logic rx_bit,
   output logic rx_bit_vld,
   output logic line_rxd_o,
   output logic line_rxd_oe,
   output logic line_txd_o,
   output logic line_txd_oe
);

   assign rx_bit      = rx_swap ? line_txd_i : line_rxd_i;
   assign rx_bit_vld  = rx_slot_on;
   assign line_rxd_o  = tx_bit;
   assign line_txd_o  = tx_bit;
   assign line_rxd_oe = tx_slot_on && tx_swap;
   assign line_txd_oe = tx_slot_on && !tx_swap;

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({line_rxd_oe, line_txd_oe})); // R8
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_slot_on |-> !(line_rxd_oe || line_txd_oe)); // R6

endmodule

// File: rtl/tdm_route_seq.sv
module tdm_route_seq #(
   parameter int N_ENT     = 16,
   parameter int CSEL_W    = 2,
   parameter int CNT_W     = 3,
   parameter int BYTE_BITS = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              tbl_sel_req,
   input  logic                              rx_sync,
   input  logic                              tx_sync,
   input  logic [N_ENT*(CNT_W+CSEL_W+3)-1:0] rx_tbl_pri,
   input  logic [N_ENT*(CNT_W+CSEL_W+3)-1:0] rx_tbl_sha,
   input  logic [N_ENT*(CNT_W+CSEL_W+3)-1:0] tx_tbl_pri,
   input  logic [N_ENT*(CNT_W+CSEL_W+3)-1:0] tx_tbl_sha,
   input  logic                              line_rxd_i,
   input  logic                              line_txd_i,
   input  logic                              tx_bit,
   output logic [CSEL_W-1:0]                 rx_chan,
   output logic                              rx_bit,
   output logic                              rx_bit_vld,
   output logic [CSEL_W-1:0]                 tx_chan,
   output logic                              line_rxd_o,
   output logic                              line_rxd_oe,
   output logic                              line_txd_o,
   output logic                              line_txd_oe,
   output logic                              rx_tbl_act,
   output logic                              tx_tbl_act,
   output logic                              rx_sync_err,
   output logic                              tx_sync_err,
   output logic                              rx_cfg_err,
   output logic                              tx_cfg_err
);

   logic rx_on, rx_sw, tx_on, tx_sw;

   tdm_route_walker #(.N_ENT(N_ENT), .CSEL_W(CSEL_W), .CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) u_rx_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync     (rx_sync),
      .sel_req  (tbl_sel_req),
      .tbl_pri  (rx_tbl_pri),
      .tbl_sha  (rx_tbl_sha),
      .slot_on  (rx_on),
      .chan     (rx_chan),
      .swap     (rx_sw),
      .sel_act  (rx_tbl_act),
      .sync_err (rx_sync_err),
      .cfg_err  (rx_cfg_err)
   );

   tdm_route_walker #(.N_ENT(N_ENT), .CSEL_W(CSEL_W), .CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) u_tx_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync     (tx_sync),
      .sel_req  (tbl_sel_req),
      .tbl_pri  (tx_tbl_pri),
      .tbl_sha  (tx_tbl_sha),
      .slot_on  (tx_on),
      .chan     (tx_chan),
      .swap     (tx_sw),
      .sel_act  (tx_tbl_act),
      .sync_err (tx_sync_err),
      .cfg_err  (tx_cfg_err)
   );

   tdm_pin_steer u_steer (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_slot_on  (rx_on),
      .rx_swap     (rx_sw),
      .tx_slot_on  (tx_on),
      .tx_swap     (tx_sw),
      .line_rxd_i  (line_rxd_i),
      .line_txd_i  (line_txd_i),
      .tx_bit      (tx_bit),
      .rx_bit      (rx_bit),
      .rx_bit_vld  (rx_bit_vld),
      .line_rxd_o  (line_rxd_o),
      .line_rxd_oe (line_rxd_oe),
      .line_txd_o  (line_txd_o),
      .line_txd_oe (line_txd_oe)
   );

   AST_RX_CHAN_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bit_vld |-> (rx_chan != '0)); // R6
   AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_chan == '0) |-> !(line_rxd_oe || line_txd_oe)); // R6

endmodule

// File: tb/tdm_route_seq_test.sv
module tdm_route_seq_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_sel_req = 1'b0, rx_sync = 1'b0, tx_sync = 1'b0;
   logic [127:0] rx_tbl_pri = '0, rx_tbl_sha = '0, tx_tbl_pri = '0, tx_tbl_sha = '0;
   logic line_rxd_i = 1'b0, line_txd_i = 1'b0, tx_bit = 1'b0;
   logic [1:0] rx_chan, tx_chan;
   logic rx_bit, rx_bit_vld, line_rxd_o, line_rxd_oe, line_txd_o, line_txd_oe;
   logic rx_tbl_act, tx_tbl_act, rx_sync_err, tx_sync_err, rx_cfg_err, tx_cfg_err;

   int checks = 0, errors = 0, cyc = 0;
   string phase_tag = "R2";

   always #10 clk = ~clk;

   tdm_route_seq uut (.*);

   function automatic logic [7:0] mk(input int cnt, input int byt, input int cs, input int sw, input int ls);
      return {ls[0], sw[0], cs[1:0], byt[0], cnt[2:0]};
   endfunction

   // behavioural reference: d = 0 receive, d = 1 transmit
   int m_run[2], m_idx[2], m_bc[2], m_sel[2], m_serr[2], m_cerr[2];

   function automatic logic [7:0] ent_of(input int d, input int s, input int i);
      logic [127:0] t;
      if (d == 0) t = s ? rx_tbl_sha : rx_tbl_pri;
      else        t = s ? tx_tbl_sha : tx_tbl_pri;
      return t[i*8 +: 8];
   endfunction

   function automatic int len_of(input logic [7:0] e);
      return e[3] ? (int'(e[2:0]) + 1) * 8 : int'(e[2:0]) + 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      for (int d = 0; d < 2; d++) begin
         if (!rst_n) begin
            m_run[d] = 0; m_idx[d] = 0; m_bc[d] = 0; m_sel[d] = 0; m_serr[d] = 0; m_cerr[d] = 0;
         end else begin
            logic [7:0] e;
            bit lb, fe, sy;
            e  = ent_of(d, m_sel[d], m_idx[d]);
            sy = (d == 0) ? rx_sync : tx_sync;
            lb = m_run[d] != 0 && m_bc[d] == len_of(e) - 1;
            fe = lb && ((m_idx[d] % 2 == 1 && e[7]) || m_idx[d] == 15);
            m_cerr[d] = (fe && e[2:0] == 0 && !e[3]) ? 1 : 0;
            m_serr[d] = 0;
            if (sy) begin
               if (m_run[d] != 0 && !fe) m_serr[d] = 1;
               else                      m_sel[d] = tbl_sel_req;
               m_run[d] = 1; m_idx[d] = 0; m_bc[d] = 0;
            end else if (lb) begin
               m_bc[d] = 0;
               if (fe) begin m_run[d] = 0; m_idx[d] = 0; end
               else m_idx[d] = m_idx[d] + 1;
            end else if (m_run[d] != 0) begin
               m_bc[d] = m_bc[d] + 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         for (int d = 0; d < 2; d++) begin
            logic [7:0] e;
            int ech, ach;
            bit on, sw;
            e   = ent_of(d, m_sel[d], m_idx[d]);
            ech = m_run[d] != 0 ? int'(e[5:4]) : 0;
            on  = ech != 0;
            sw  = on && e[6];
            ach = (d == 0) ? int'(rx_chan) : int'(tx_chan);
            chk(ach == ech, (ech == 0 && m_run[d] != 0) ? "R6" : "R3", ach, ech);
            chk(((d == 0) ? rx_tbl_act : tx_tbl_act) == m_sel[d][0], "R9",
                (d == 0) ? rx_tbl_act : tx_tbl_act, m_sel[d]);
            chk(((d == 0) ? rx_sync_err : tx_sync_err) == m_serr[d][0], "R10",
                (d == 0) ? rx_sync_err : tx_sync_err, m_serr[d]);
            chk(((d == 0) ? rx_cfg_err : tx_cfg_err) == m_cerr[d][0], "R11",
                (d == 0) ? rx_cfg_err : tx_cfg_err, m_cerr[d]);
            if (d == 0) begin
               chk(rx_bit_vld == on, phase_tag, rx_bit_vld, on);
               if (on) chk(rx_bit == (sw ? line_txd_i : line_rxd_i), "R7", rx_bit, sw ? line_txd_i : line_rxd_i);
            end else begin
               chk(line_rxd_oe == sw, "R8", line_rxd_oe, sw);
               chk(line_txd_oe == (on && !sw), "R8", line_txd_oe, on && !sw);
               if (line_rxd_oe) chk(line_rxd_o == tx_bit, "R8", line_rxd_o, tx_bit);
               if (line_txd_oe) chk(line_txd_o == tx_bit, "R8", line_txd_o, tx_bit);
            end
         end
      end
   end

   task automatic step(input int n, input int rxp, input int txp);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #2;
         rx_sync    = (rxp > 0) && (k % rxp == 0);
         tx_sync    = (txp > 0) && (k % txp == 0);
         line_rxd_i = 1'($urandom);
         line_txd_i = 1'($urandom);
         tx_bit     = 1'($urandom);
      end
      @(negedge clk); #2;
      rx_sync = 1'b0; tx_sync = 1'b0;
   endtask

   initial begin
      rx_tbl_pri[ 7: 0] = mk(2, 0, 1, 0, 0);
      rx_tbl_pri[15: 8] = mk(0, 1, 2, 1, 0);
      rx_tbl_pri[23:16] = mk(1, 0, 0, 0, 1);
      rx_tbl_pri[31:24] = mk(3, 0, 3, 0, 1);
      tx_tbl_pri[ 7: 0] = mk(1, 0, 2, 1, 0);
      tx_tbl_pri[15: 8] = mk(0, 0, 1, 0, 1);
      for (int i = 0; i < 16; i++) rx_tbl_sha[i*8 +: 8] = mk(0, 0, i % 4, (i % 3 == 0) ? 1 : 0, 0);
      tx_tbl_sha[ 7: 0] = mk(0, 1, 3, 0, 0);
      tx_tbl_sha[15: 8] = mk(1, 0, 1, 1, 1);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rx_chan == 0 && tx_chan == 0, "R1", {rx_chan, tx_chan}, 0);
      chk(!line_rxd_oe && !line_txd_oe && !rx_bit_vld, "R1", {line_rxd_oe, line_txd_oe, rx_bit_vld}, 0);
      chk(!rx_tbl_act && !tx_tbl_act, "R1", {rx_tbl_act, tx_tbl_act}, 0);
      #2 rst_n = 1'b1;
      step(5, 0, 0);
      chk(rx_chan == 0 && !line_txd_oe, "R1", {rx_chan, line_txd_oe}, 0);

      phase_tag = "R2"; step(1, 1, 0); step(25, 0, 0);   // receive frame, even last ignored
      phase_tag = "R5"; step(1, 1, 0); step(30, 0, 0);
      phase_tag = "R12"; step(40, 0, 3);                  // clean back-to-back transmit
      step(20, 0, 2);                                      // early transmit syncs
      step(12, 7, 5);
      step(30, 0, 0);
      phase_tag = "R4"; tbl_sel_req = 1'b1;
      step(1, 1, 1); step(4, 0, 0); step(1, 1, 0);        // early sync, no switch
      step(30, 0, 0); step(1, 1, 1); step(40, 0, 0);      // switch at boundary
      step(30, 17, 11);
      tbl_sel_req = 1'b0; step(1, 1, 1); step(40, 0, 0);
      step(1, 1, 1); step(40, 0, 0);
      for (int r = 0; r < 3000; r++) begin
         @(negedge clk); #2;
         rx_sync     = ($urandom % 23) == 0;
         tx_sync     = ($urandom % 9) == 0;
         if (($urandom % 50) == 0) tbl_sel_req = ~tbl_sel_req;
         line_rxd_i  = 1'($urandom);
         line_txd_i  = 1'($urandom);
         tx_bit      = 1'($urandom);
      end
      @(negedge clk); #2; rx_sync = 1'b0; tx_sync = 1'b0;
      step(20, 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule